// File: doc/BRIEF.md
# Byte-Wide Galois Scrambler

This block whitens a byte stream for a serial physical layer. It holds a 16-bit linear feedback shift register built in one-to-many (Galois) form, with feedback polynomial x^16 + x^5 + x^4 + x^3 + 1. On every byte-clock cycle that carries a data byte, the register takes eight single-bit steps. The bit that leaves the register on each step is XORed into one bit of the incoming byte, which gives the scrambled byte.

The byte clock runs at one eighth of the bit rate, so the eight steps are unrolled into combinational logic ahead of one state register. Scrambling and descrambling are the same operation. A receiver uses a second copy of this block, seeded with the same value, to recover the original bytes.

The register can be reseeded at any time. An all-zero seed would stop the sequence for good, so it is replaced with the default seed.

Top module: `byte_scrambler`

## Requirements
- R1: While `rst_n` is low, `lfsr_state` equals the default seed (parameter, 0x0001) and `out_valid` is 0. Reset is asynchronous on assertion.
- R2: One single-bit step maps state s to {s[0], s[15:1]}, with s[0] also XORed into bits 12, 11 and 10. For example, 0x0001 steps to 0x9C00, and 0x0027 reaches 0x20A8 after eight steps.
- R3: On a cycle with `in_valid` high, the state advances exactly eight single-bit steps. Data bit k (k = 0 is the LSB) is XORed with bit 0 of the state before step k.
- R4: With `in_valid` and `seed_load` both low, `lfsr_state` does not change.
- R5: A cycle with `seed_load` high and a non-zero `seed_value` makes `lfsr_state` equal to `seed_value` on the next cycle. No steps are taken in that cycle.
- R6: A `seed_load` with `seed_value` = 0x0000 loads the default seed instead.
- R7: `out_valid` equals `in_valid` delayed by one clock. `out_byte` is registered, so the scrambled byte appears one cycle after its input.
- R8: When `seed_load` and `in_valid` are high in the same cycle, the state takes the seed and the byte is scrambled with the state as it was before the load. `out_valid` still follows `in_valid`.
- R9: Feeding the output of one instance into a second instance loaded with the same seed returns the original byte stream.
- R10: After reset, `lfsr_state` is never 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| seed_load | input | 1 | Load `seed_value` into the state this cycle |
| seed_value | input | 16 | Seed to load; 0 is replaced with the default seed |
| in_valid | input | 1 | `in_byte` is valid; advances the state by eight steps |
| in_byte | input | 8 | Data byte to scramble or descramble |
| out_byte | output | 8 | Scrambled byte, one cycle after its input |
| out_valid | output | 1 | `out_byte` is valid |
| lfsr_state | output | 16 | Current register state |

## Verification
A seed load and a data byte can arrive in the same cycle, and this collision is the main corner case. The bench first loads 0x0001, then raises `seed_load` with 0x0027 while it presents 0x00 as valid data. The scrambled output must be 0x01, which is the keystream of the old state. The state must read 0x0027 with no steps taken. The next byte, 0x00, must then come out as 0x27, which shows that the new seed took effect.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned STATE_W = 16;
  localparam int unsigned BYTE_W  = 8;
  // feedback positions 12, 11 and 10 after the right shift
  localparam logic [STATE_W-1:0] TAP_MASK     = 16'h1C00;
  localparam logic [STATE_W-1:0] SEED_DEFAULT = 16'h0001;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [BYTE_W-1:0]  byte_t;

  function automatic state_t galois_step(input state_t s, input state_t mask);
    state_t rot;
    rot = {s[0], s[STATE_W-1:1]};
    return s[0] ? (rot ^ mask) : rot;
  endfunction
endpackage

// File: rtl/scr_keystream.sv
module scr_keystream
  import scr_pkg::*;
#(
  parameter int unsigned           STEPS = BYTE_W,
  parameter logic [STATE_W-1:0]    MASK  = TAP_MASK
) (
  input  logic [STATE_W-1:0] cur_state,
  output logic [STATE_W-1:0] adv_state,
  output logic [STEPS-1:0]   key_bits
);
  logic [STATE_W-1:0] chain [0:STEPS];

  assign chain[0] = cur_state;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    assign key_bits[k]  = chain[k][0];
    assign chain[k+1]   = galois_step(chain[k], MASK);
  end

  assign adv_state = chain[STEPS];
endmodule

// File: rtl/scr_state_reg.sv
module scr_state_reg
  import scr_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED_RST = SEED_DEFAULT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_load,
  input  logic [STATE_W-1:0] seed_value,
  input  logic               advance,
  input  logic [STATE_W-1:0] adv_state,
  output logic [STATE_W-1:0] state_q
);
  logic [STATE_W-1:0] state_d;
  logic               state_en;
  logic [STATE_W-1:0] seed_safe;

  always_comb begin
    seed_safe = (seed_value == '0) ? SEED_RST : seed_value;
    state_en  = seed_load | advance;
    state_d   = seed_load ? seed_safe : adv_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_RST;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !advance) |=> $stable(state_q)); // R4
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_value != '0) |=> state_q == $past(seed_value)); // R5
  AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_value == '0) |=> state_q == SEED_RST); // R6
endmodule

// File: rtl/scr_out_reg.sv
module scr_out_reg
  import scr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [BYTE_W-1:0] key_bits,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    byte_d = in_byte ^ key_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_byte <= '0;
    end else if (in_valid) begin
      out_byte <= byte_d;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_byte)); // R7
endmodule

// File: rtl/byte_scrambler.sv
module byte_scrambler
  import scr_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED_RST = SEED_DEFAULT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seed_load,
  input  logic [STATE_W-1:0] seed_value,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic [BYTE_W-1:0]  out_byte,
  output logic               out_valid,
  output logic [STATE_W-1:0] lfsr_state
);
  logic [STATE_W-1:0] adv_state;
  logic [BYTE_W-1:0]  key_bits;

  scr_keystream #(.STEPS(BYTE_W), .MASK(TAP_MASK)) u_key (
    .cur_state (lfsr_state),
    .adv_state (adv_state),
    .key_bits  (key_bits)
  );

  scr_state_reg #(.SEED_RST(SEED_RST)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .advance    (in_valid),
    .adv_state  (adv_state),
    .state_q    (lfsr_state)
  );

  scr_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .key_bits  (key_bits),
    .out_byte  (out_byte),
    .out_valid (out_valid)
  );

  // R3 / R8: a valid byte without a load moves the state off its old value
  AST_ADVANCE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !seed_load) |=> lfsr_state != $past(lfsr_state)); // R3
  AST_LOAD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seed_load && seed_value != '0) |=> lfsr_state == $past(seed_value)); // R8
endmodule

// File: tb/byte_scrambler_test.sv
module byte_scrambler_test;
  logic        clk;
  logic        rst_n;
  logic        sl;
  logic [15:0] sv;
  logic        dv;
  logic [7:0]  db;
  logic [7:0]  ob;
  logic        ov;
  logic [15:0] st;
  logic [7:0]  rb;
  logic        rv;
  logic [15:0] rst_st;

  int n_chk;
  int n_fail;
  bit done;

  byte_scrambler uut (
    .clk(clk), .rst_n(rst_n), .seed_load(sl), .seed_value(sv),
    .in_valid(dv), .in_byte(db), .out_byte(ob), .out_valid(ov), .lfsr_state(st)
  );

  byte_scrambler udesc (
    .clk(clk), .rst_n(rst_n), .seed_load(sl), .seed_value(sv),
    .in_valid(ov), .in_byte(ob), .out_byte(rb), .out_valid(rv), .lfsr_state(rst_st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // model of one step, from R2
  function automatic logic [15:0] step1(input logic [15:0] s);
    logic [15:0] r;
    r = {s[0], s[15:1]};
    if (s[0]) r = r ^ 16'h1C00;
    return r;
  endfunction

  // {seed, data in, expected out, expected state after one byte}
  localparam logic [47:0] VEC [0:3] = '{
    {16'h0001, 8'h00, 8'h01, 16'h0138},
    {16'h0027, 8'hFF, 8'hD8, 16'h20A8},
    {16'h8000, 8'hA5, 8'hA5, 16'h0080},
    {16'h0000, 8'h3C, 8'h3D, 16'h0138}
  };

  localparam int N = 24;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ms;
    logic [7:0]  ks;
    logic [7:0]  stream [0:N-1];
    logic [7:0]  kexp   [0:N-1];
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; sl = 0; sv = '0; dv = 0; db = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", st, 16'h0001);
    chk("R1 reset valid", ov, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 first single step: checked via byte from 0x0001 in the table
    for (int i = 0; i < 4; i++) begin
      sl = 1; sv = VEC[i][47:32];
      @(negedge clk);
      chk(VEC[i][47:32] == 0 ? "R6 zero seed" : "R5 seed load", st,
          VEC[i][47:32] == 0 ? 16'h0001 : VEC[i][47:32]);
      sl = 0; dv = 1; db = VEC[i][31:24];
      @(negedge clk);
      dv = 0;
      chk("R3 scrambled byte", ob, VEC[i][23:16]);
      chk("R2 state after eight steps", st, VEC[i][15:0]);
      chk("R7 valid latency", ov, 1'b1);
      @(negedge clk);
      chk("R7 valid drops", ov, 1'b0);
    end

    // R4 idle hold with changing data
    sl = 1; sv = 16'hBEEF;
    @(negedge clk);
    sl = 0; db = 8'h55;
    repeat (3) @(negedge clk);
    chk("R4 idle hold", st, 16'hBEEF);
    chk("R4 no output", ov, 1'b0);

    // R8 load and data in the same cycle
    sl = 1; sv = 16'h0001;
    @(negedge clk);
    sv = 16'h0027; dv = 1; db = 8'h00;
    @(negedge clk);
    sl = 0; db = 8'h00;
    chk("R8 byte uses old state", ob, 8'h01);
    chk("R8 state takes seed", st, 16'h0027);
    chk("R8 valid kept", ov, 1'b1);
    @(negedge clk);
    dv = 0;
    chk("R8 next byte uses seed", ob, 8'h27);
    chk("R8 state advanced", st, 16'h20A8);
    @(negedge clk);

    // R9 round trip through two instances, R3 against the model
    for (int i = 0; i < N; i++) stream[i] = 8'(i * 37 + 5);
    sl = 1; sv = 16'h1D0F;
    @(negedge clk);
    sl = 0; ms = 16'h1D0F;
    for (int i = 0; i < N + 2; i++) begin
      if (i >= 1 && i <= N) chk("R3 stream byte", ob, stream[i-1] ^ kexp[i-1]);
      if (i >= 2) begin
        chk("R9 round trip valid", rv, 1'b1);
        chk("R9 round trip byte", rb, stream[i-2]);
      end
      if (i < N) begin
        ks = '0;
        for (int k = 0; k < 8; k++) begin
          ks[k] = ms[0];
          ms = step1(ms);
        end
        kexp[i] = ks;
        dv = 1; db = stream[i];
      end else begin
        dv = 0;
      end
      @(negedge clk);
    end
    chk("R3 model state after stream", st, ms);

    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #2;
    chk("R1 async reset state", st, 16'h0001);
    chk("R1 async reset valid", ov, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule